// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block sits beside a synchronous memory interface and manages a low-power sleep state. An external sleep request is asynchronous and active high. It is first brought into the clock domain. A fixed entry window then runs, and after it the interface is put to sleep: command inputs are no longer accepted and the data outputs are forced to high impedance. When the request is withdrawn, a fixed wake window runs before normal operation resumes. Memory contents and interface registers are not touched by the sequencer, so all state survives a sleep period.

The block also watches the decoded command stream. A command that starts an array access while entry is under way will not reliably complete, so it is flagged. During the wake window only deselect and read are allowed, so a write there is also flagged. Each offending command produces a one-cycle error pulse. If the request is withdrawn before entry finishes, the sequencer abandons entry and goes straight into the wake window.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, in_ignore, out_hiz, sleeping, waking and proto_err are all low.
- R2: The sleep request passes through a two-flop synchroniser. A change on sleep_req reaches the phase logic two rising edges after it is first sampled.
- R3: The entry window starts on the third rising edge after sleep_req is first sampled high and lasts two cycles. During entry, in_ignore, out_hiz, sleeping and waking all stay low.
- R4: After the entry window completes, sleeping, in_ignore and out_hiz are high. They stay high until the synchronised request falls.
- R5: The wake window starts two rising edges after the synchronised request falls and lasts two cycles. During wake, waking, in_ignore and out_hiz are high and sleeping is low.
- R6: When the wake window ends, all four status outputs are low again.
- R7: If the synchronised request falls during the entry window, entry is abandoned and the wake window follows at once. In this case sleeping never rises.
- R8: A write (cmd_code 2'b10) sampled during the wake window raises proto_err for exactly the next cycle. Deselect and read sampled during wake raise no error.
- R9: A read (2'b01) or a write (2'b10) sampled during the entry window raises proto_err for the next cycle.
- R10: A command sampled while fully awake or fully asleep never raises proto_err.
- R11: Command encoding: 2'b00 is deselect, 2'b01 is read, 2'b10 is write, and 2'b11 is treated as deselect and is never flagged.
- R12: If the synchronised request rises again during the wake window, the entry window restarts from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cmd_code | input | 2 | Decoded command of the current cycle |
| in_ignore | output | 1 | Interface inputs must be ignored |
| out_hiz | output | 1 | Data outputs forced to high impedance |
| sleeping | output | 1 | Sleep state reached |
| waking | output | 1 | Wake window in progress |
| proto_err | output | 1 | One-cycle pulse for an illegal command |

## Verification
Counted from the rising edge that first samples a new sleep_req level, the status outputs change after edge 2 (entry start, with no visible change), edge 4 (sleeping) and edge h+2 (wake start). Here h is the number of edges at which the request was high. proto_err reflects the command held during the previous cycle and the phase of that cycle. The bench drives each input on a falling edge and samples every output on the next falling edge. It derives the expected vector for edge k from closed-form formulas in h and k. It sweeps h from 0 to 10 with a rotating command code and adds a directed run in which the request rises again during wake.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_ENTER   = 2'd1,
    PH_DORMANT = 2'd2,
    PH_WAKE    = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_RSV  = 2'b11
  } cmd_e;

  // true when the command starts an array access
  function automatic logic cmd_is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  function automatic logic cmd_is_write(input cmd_e c);
    return c == CMD_WR;
  endfunction

  // last cycle of a window of len cycles, counted from zero
  function automatic logic window_last(input int cnt, input int len);
    return cnt >= (len - 1);
  endfunction

  // command legality per phase
  function automatic logic cmd_violates(input phase_e ph, input cmd_e c);
    logic bad;
    case (ph)
      PH_ENTER: bad = cmd_is_access(c);
      PH_WAKE:  bad = cmd_is_write(c);
      default:  bad = 1'b0;
    endcase
    return bad;
  endfunction

  // gating derived from phase
  function automatic logic phase_gates_inputs(input phase_e ph);
    return (ph == PH_DORMANT) || (ph == PH_WAKE);
  endfunction

endpackage

// File: rtl/sleep_req_sync.sv
module sleep_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= 1'b0;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/sleep_phase_fsm.sv
module sleep_phase_fsm
  import sleep_seq_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_s,
  output phase_e phase
);
  localparam int MAXW  = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
  localparam int CNT_W = $clog2(MAXW + 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             entry_done, wake_done;

  assign entry_done = window_last(int'(cnt_q), ENTRY_CYC);
  assign wake_done  = window_last(int'(cnt_q), WAKE_CYC);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_RUN: begin
        if (req_s) begin
          ph_d  = PH_ENTER;
          cnt_d = '0;
        end
      end
      PH_ENTER: begin
        if (!req_s) begin
          ph_d  = PH_WAKE;
          cnt_d = '0;
        end else if (entry_done) begin
          ph_d  = PH_DORMANT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DORMANT: begin
        if (!req_s) begin
          ph_d  = PH_WAKE;
          cnt_d = '0;
        end
      end
      PH_WAKE: begin
        if (req_s) begin
          ph_d  = PH_ENTER;
          cnt_d = '0;
        end else if (wake_done) begin
          ph_d  = PH_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        ph_d  = PH_RUN;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_RUN;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/sleep_cmd_guard.sv
module sleep_cmd_guard
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic [1:0] cmd_code,
  output logic       err_pulse
);
  logic violation;

  assign violation = cmd_violates(phase, cmd_e'(cmd_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= violation;
  end
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int WAKE_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [1:0] cmd_code,
  output logic       in_ignore,
  output logic       out_hiz,
  output logic       sleeping,
  output logic       waking,
  output logic       proto_err
);
  logic   req_s;
  phase_e phase;
  logic   ph_entering;
  logic   ph_gated;

  sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sleep_req),
    .q_sync  (req_s)
  );

  sleep_phase_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .req_s (req_s),
    .phase (phase)
  );

  sleep_cmd_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .cmd_code  (cmd_code),
    .err_pulse (proto_err)
  );

  assign ph_entering = (phase == PH_ENTER);
  assign ph_gated    = phase_gates_inputs(phase);
  assign in_ignore   = ph_gated;
  assign out_hiz     = ph_gated;
  assign sleeping    = (phase == PH_DORMANT);
  assign waking      = (phase == PH_WAKE);
endmodule

// File: rtl/sleep_seq_ctrl_chk.sv
module sleep_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_code,
  input logic       in_ignore,
  input logic       out_hiz,
  input logic       sleeping,
  input logic       waking,
  input logic       proto_err,
  input logic       entering
);
  a_r3_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entering, sleeping, waking}));

  a_r3_sleep_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> $past(entering));

  a_r4_dormant_gates: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> (in_ignore && out_hiz));

  a_r5_wake_gates: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> (in_ignore && out_hiz && !sleeping));

  a_r6_run_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(entering || sleeping || waking) |-> (!in_ignore && !out_hiz));

  a_r7_exit_through_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> waking);

  a_r8_write_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (waking && cmd_code == 2'b10) |=> proto_err);

  a_r9_access_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (entering && (cmd_code == 2'b01 || cmd_code == 2'b10)) |=> proto_err);

  a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(entering || waking));
endmodule

bind sleep_seq_ctrl sleep_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_code  (cmd_code),
  .in_ignore (in_ignore),
  .out_hiz   (out_hiz),
  .sleeping  (sleeping),
  .waking    (waking),
  .proto_err (proto_err),
  .entering  (ph_entering)
);

// File: tb/sim_sleep_seq_ctrl.sv
module sim_sleep_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic       in_ignore, out_hiz, sleeping, waking, proto_err;

  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_seq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .cmd_code  (cmd_code),
    .in_ignore (in_ignore),
    .out_hiz   (out_hiz),
    .sleeping  (sleeping),
    .waking    (waking),
    .proto_err (proto_err)
  );

  // vector order: {in_ignore, out_hiz, sleeping, waking, proto_err}
  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {in_ignore, out_hiz, sleeping, waking, proto_err};
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t got %b expected %b", tag, $time, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // request high for h edges, command code rotating each cycle
  task automatic run_hold(input int h);
    bit p_en = 1'b0;
    bit p_wk = 1'b0;
    for (int k = 0; k <= h + 6; k++) begin
      logic [1:0] c;
      bit en, wk, sl, er;
      string tag;
      c = 2'((k + h) % 4);
      sleep_req = (k < h);
      cmd_code  = c;
      step();
      en = (k >= 2) && (k <= ((h + 1 < 3) ? h + 1 : 3));
      wk = (h > 0) && ((k == h + 2) || (k == h + 3));
      sl = (h >= 3) && (k >= 4) && (k <= h + 1);
      er = (p_en && (c == 2'b01 || c == 2'b10)) || (p_wk && c == 2'b10);
      if (p_wk && c == 2'b10)                 tag = "R8 write in wake";
      else if (p_en && c != 2'b11 && c != 2'b00) tag = "R9 access in entry";
      else if (p_en || p_wk)                  tag = "R11 legal code no error";
      else if (h > 0 && h < 3 && wk)          tag = "R7 aborted entry";
      else if (sl)                            tag = "R4 asleep";
      else if (wk)                            tag = "R5 wake window";
      else if (en)                            tag = "R3 entry window";
      else if (h > 0 && k == h + 4)           tag = "R6 back to run";
      else if (k < 2)                         tag = "R2 sync latency";
      else                                    tag = "R10 no error when idle";
      chk($sformatf("%s h=%0d k=%0d", tag, h, k), {sl | wk, sl | wk, sl, wk, er});
      p_en = en;
      p_wk = wk;
    end
    cmd_code = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, held and just after release
    repeat (2) @(negedge clk);
    chk("R1 in reset", 5'b00000);
    rst_n = 1'b1;
    step();
    chk("R1 after release", 5'b00000);
    repeat (3) step();

    for (int h = 0; h <= 10; h++) begin
      run_hold(h);
    end

    // R12: request drops for one edge, then returns during wake
    for (int k = 0; k <= 14; k++) begin
      bit sl, wk;
      sleep_req = (k < 3) || (k >= 4 && k < 10);
      cmd_code  = 2'b00;
      step();
      sl = (k == 4) || (k >= 8 && k <= 11);
      wk = (k == 5) || (k == 12) || (k == 13);
      chk($sformatf("R12 re-entry from wake k=%0d", k), {sl | wk, sl | wk, sl, wk, 1'b0});
    end

    // R10: commands while asleep are not flagged
    sleep_req = 1'b1;
    repeat (6) step();
    for (int c = 0; c < 4; c++) begin
      cmd_code = 2'(c);
      step();
      chk($sformatf("R10 asleep code=%0d", c), 5'b11100);
    end
    cmd_code  = 2'b00;
    sleep_req = 1'b0;
    repeat (6) step();
    chk("R6 idle after wake", 5'b00000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule